// File: doc/BRIEF.md
# Split-Mode 64-bit Arithmetic Unit

This block is a three-address arithmetic unit with a private register file of four 64-bit registers. Each operation reads two source registers, computes a result and writes it to a destination register on the next rising clock edge. The unit adds, subtracts, applies XOR, AND, OR and NOT, rotates by a bit amount in either direction, rotates by a whole number of bytes in either direction, and loads an immediate value.

A mode input selects between one 64-bit datapath and two independent 32-bit lanes. In 32-bit mode the carry chain is cut at the lane boundary and each rotation wraps inside its own lane. The operand selectors then name eight 32-bit virtual registers, so a 32-bit write changes one half of a physical register and leaves the other half as it was. A combinational read port lets the surrounding logic observe any physical register.

Top module: `split_alu`

## Requirements
- R1: While rst_ni is low, all four registers are cleared to zero.
- R2: A 3-bit selector s names physical register s[2:1] in both modes. In 32-bit mode (split_i=1), s[0]=1 selects bits 63:32 and s[0]=0 selects bits 31:0. Only the destination's physical register can change. rd_data_o shows register rd_sel_i combinationally.
- R3: A register changes only on a rising clock edge where valid_i is 1. The new value is visible on rd_data_o after that edge.
- R4: In 64-bit mode (split_i=0), op 0 (ADD) writes a+b and op 1 (SUB) writes a-b, both modulo 2^64, with the carry crossing bit 31 into bit 32.
- R5: In 32-bit mode, ADD and SUB act on the selected 32-bit values modulo 2^32. No carry or borrow crosses the lane boundary.
- R6: In 32-bit mode every write changes only the selected half of the destination. The other half keeps its value.
- R7: Op 2 writes a XOR b, op 3 writes a AND b, op 4 writes a OR b, and op 5 writes NOT a. These apply at the width of the mode.
- R8: In 64-bit mode, op 6 rotates a left and op 7 rotates a right by b[5:0] bit positions.
- R9: In 32-bit mode, op 6 and op 7 rotate the selected 32-bit value of a by b[4:0] bit positions.
- R10: Op 8 rotates a left and op 9 rotates a right in whole bytes. The byte count is b[2:0] in 64-bit mode and b[1:0] in 32-bit mode.
- R11: Op 10 (LOAD) writes imm_i in 64-bit mode, and imm_i[31:0] into the selected half in 32-bit mode.
- R12: Opcodes 11 to 15 write nothing, even when valid_i is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the presented operation this cycle |
| op_i | input | 4 | Operation code |
| split_i | input | 1 | 1 selects two 32-bit lanes, 0 selects one 64-bit datapath |
| src_a_i | input | 3 | First source selector |
| src_b_i | input | 3 | Second source selector |
| dst_i | input | 3 | Destination selector |
| imm_i | input | 64 | Immediate value for LOAD |
| rd_sel_i | input | 2 | Physical register shown on rd_data_o |
| rd_data_o | output | 64 | Contents of the selected register |

## Verification
The checker watches the register file on every cycle. It confirms that:
- idle cycles and unused opcodes leave every register unchanged;
- only the destination's physical register can change;
- a 32-bit write preserves the unselected half;
- 64-bit add, 32-bit add and 64-bit XOR produce the sum or XOR of the previous cycle's source values.

Only the bench's scenarios show the rest:
- rotate amounts at the wrap points of each mode (zero, width minus one, and amounts whose upper bits must be ignored);
- subtraction borrow at the lane boundary;
- byte rotates;
- immediate loads;
- operations whose sources alias the destination.

The bench compares each of these against an independent model after every operation.

// File: rtl/split_alu_pkg.sv
package split_alu_pkg;
  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_XOR  = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_NOT  = 4'd5,
    OP_ROL  = 4'd6,
    OP_ROR  = 4'd7,
    OP_BROL = 4'd8,
    OP_BROR = 4'd9,
    OP_LOAD = 4'd10
  } alu_op_e;

  localparam int unsigned NUM_LANES = 2;
endpackage

// File: rtl/split_alu_regfile.sv
module split_alu_regfile #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned DW    = split_alu_pkg::NUM_LANES * LANE_W,
  localparam int unsigned IDX_W = $clog2(NREGS)
) (
  input  logic                                    clk_i,
  input  logic                                    rst_ni,
  input  logic                                    wr_en_i,
  input  logic [IDX_W-1:0]                        wr_idx_i,
  input  logic [split_alu_pkg::NUM_LANES-1:0]     wr_lane_i,
  input  logic [DW-1:0]                           wr_data_i,
  input  logic [IDX_W-1:0]                        rd_a_idx_i,
  input  logic [IDX_W-1:0]                        rd_b_idx_i,
  input  logic [IDX_W-1:0]                        rd_c_idx_i,
  output logic [DW-1:0]                           rd_a_o,
  output logic [DW-1:0]                           rd_b_o,
  output logic [DW-1:0]                           rd_c_o,
  output logic [NREGS*DW-1:0]                     regs_o
);
  logic [DW-1:0] rf_q [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    for (genvar l = 0; l < split_alu_pkg::NUM_LANES; l++) begin : g_lane
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          rf_q[g][l*LANE_W +: LANE_W] <= '0;
        else if (wr_en_i && wr_lane_i[l] && (wr_idx_i == IDX_W'(g)))
          rf_q[g][l*LANE_W +: LANE_W] <= wr_data_i[l*LANE_W +: LANE_W];
      end
    end
    assign regs_o[g*DW +: DW] = rf_q[g];
  end

  assign rd_a_o = rf_q[rd_a_idx_i];
  assign rd_b_o = rf_q[rd_b_idx_i];
  assign rd_c_o = rf_q[rd_c_idx_i];
endmodule

// File: rtl/split_alu_addsub.sv
module split_alu_addsub #(
  parameter int unsigned LANE_W = 32,
  localparam int unsigned NL    = split_alu_pkg::NUM_LANES,
  localparam int unsigned DW    = NL * LANE_W
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          sub_i,
  input  logic          split_i,
  output logic [DW-1:0] res_o
);
  logic [NL:0]   carry;
  logic [DW-1:0] b_eff;

  assign b_eff    = sub_i ? ~b_i : b_i;
  assign carry[0] = sub_i;

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LANE_W:0] sum;
    logic            cin;
    // split mode restarts the chain in each lane with the subtract carry-in
    if (l == 0) begin : g_first
      assign cin = carry[0];
    end else begin : g_next
      assign cin = split_i ? sub_i : carry[l];
    end
    assign sum = {1'b0, a_i[l*LANE_W +: LANE_W]} + {1'b0, b_eff[l*LANE_W +: LANE_W]}
               + {{LANE_W{1'b0}}, cin};
    assign res_o[l*LANE_W +: LANE_W] = sum[LANE_W-1:0];
    assign carry[l+1] = sum[LANE_W];
  end
endmodule

// File: rtl/split_alu_rotate.sv
module split_alu_rotate #(
  parameter int unsigned LANE_W = 32,
  localparam int unsigned NL    = split_alu_pkg::NUM_LANES,
  localparam int unsigned DW    = NL * LANE_W,
  localparam int unsigned FSH   = $clog2(DW),
  localparam int unsigned LSH   = $clog2(LANE_W),
  localparam int unsigned FBY   = $clog2(DW / 8),
  localparam int unsigned LBY   = $clog2(LANE_W / 8)
) (
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  logic          split_i,
  input  logic          right_i,
  input  logic          byte_i,
  output logic [DW-1:0] res_o
);
  logic [FSH-1:0]  famt_raw, famt;
  logic [2*DW-1:0] fdbl;
  logic [DW-1:0]   full_res, lane_res;

  assign famt_raw = byte_i ? {b_i[FBY-1:0], 3'b000} : b_i[FSH-1:0];
  // right rotate by n equals left rotate by width-n (width is a power of two)
  assign famt     = right_i ? (~famt_raw + FSH'(1)) : famt_raw;
  assign fdbl     = {a_i, a_i} << famt;
  assign full_res = fdbl[2*DW-1:DW];

  for (genvar l = 0; l < NL; l++) begin : g_lane
    logic [LSH-1:0]      lamt_raw, lamt;
    logic [2*LANE_W-1:0] ldbl;
    logic [LANE_W-1:0]   al, bl;
    assign al       = a_i[l*LANE_W +: LANE_W];
    assign bl       = b_i[l*LANE_W +: LANE_W];
    assign lamt_raw = byte_i ? {bl[LBY-1:0], 3'b000} : bl[LSH-1:0];
    assign lamt     = right_i ? (~lamt_raw + LSH'(1)) : lamt_raw;
    assign ldbl     = {al, al} << lamt;
    assign lane_res[l*LANE_W +: LANE_W] = ldbl[2*LANE_W-1:LANE_W];
  end

  assign res_o = split_i ? lane_res : full_res;
endmodule

// File: rtl/split_alu.sv
module split_alu #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned DW    = split_alu_pkg::NUM_LANES * LANE_W,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned SEL_W = IDX_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [3:0]       op_i,
  input  logic             split_i,
  input  logic [SEL_W-1:0] src_a_i,
  input  logic [SEL_W-1:0] src_b_i,
  input  logic [SEL_W-1:0] dst_i,
  input  logic [DW-1:0]    imm_i,
  input  logic [IDX_W-1:0] rd_sel_i,
  output logic [DW-1:0]    rd_data_o
);
  import split_alu_pkg::*;

  logic [DW-1:0]       rd_a, rd_b;
  logic [NREGS*DW-1:0] rf_flat;
  logic [LANE_W-1:0]   a_half, b_half;
  logic [DW-1:0]       a_op, b_op, imm_op;
  logic [DW-1:0]       as_res, rot_res;
  logic [DW-1:0]       result;
  logic [NUM_LANES-1:0] wr_lane;
  logic                wr_en;
  alu_op_e             op;

  assign op = alu_op_e'(op_i);

  // virtual 32-bit register: bit 0 of the selector picks the upper half
  assign a_half = src_a_i[0] ? rd_a[DW-1:LANE_W] : rd_a[LANE_W-1:0];
  assign b_half = src_b_i[0] ? rd_b[DW-1:LANE_W] : rd_b[LANE_W-1:0];
  assign a_op   = split_i ? {NUM_LANES{a_half}} : rd_a;
  assign b_op   = split_i ? {NUM_LANES{b_half}} : rd_b;
  assign imm_op = split_i ? {NUM_LANES{imm_i[LANE_W-1:0]}} : imm_i;

  split_alu_addsub #(.LANE_W(LANE_W)) i_addsub (
    .a_i    (a_op),
    .b_i    (b_op),
    .sub_i  (op == OP_SUB),
    .split_i(split_i),
    .res_o  (as_res)
  );

  split_alu_rotate #(.LANE_W(LANE_W)) i_rotate (
    .a_i    (a_op),
    .b_i    (b_op),
    .split_i(split_i),
    .right_i((op == OP_ROR) || (op == OP_BROR)),
    .byte_i ((op == OP_BROL) || (op == OP_BROR)),
    .res_o  (rot_res)
  );

  always_comb begin
    case (op)
      OP_ADD, OP_SUB:                    result = as_res;
      OP_XOR:                            result = a_op ^ b_op;
      OP_AND:                            result = a_op & b_op;
      OP_OR:                             result = a_op | b_op;
      OP_NOT:                            result = ~a_op;
      OP_ROL, OP_ROR, OP_BROL, OP_BROR:  result = rot_res;
      OP_LOAD:                           result = imm_op;
      default:                           result = '0;
    endcase
  end

  assign wr_en = valid_i && (op_i <= 4'(OP_LOAD));

  always_comb begin
    if (!split_i)      wr_lane = '1;
    else if (dst_i[0]) wr_lane = NUM_LANES'(2);
    else               wr_lane = NUM_LANES'(1);
  end

  split_alu_regfile #(.LANE_W(LANE_W), .NREGS(NREGS)) i_regfile (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (dst_i[SEL_W-1:1]),
    .wr_lane_i (wr_lane),
    .wr_data_i (result),
    .rd_a_idx_i(src_a_i[SEL_W-1:1]),
    .rd_b_idx_i(src_b_i[SEL_W-1:1]),
    .rd_c_idx_i(rd_sel_i),
    .rd_a_o    (rd_a),
    .rd_b_o    (rd_b),
    .rd_c_o    (rd_data_o),
    .regs_o    (rf_flat)
  );
endmodule

// File: rtl/split_alu_checker.sv
module split_alu_checker #(
  parameter int unsigned LANE_W = 32,
  parameter int unsigned NREGS  = 4,
  localparam int unsigned DW    = 2 * LANE_W,
  localparam int unsigned IDX_W = $clog2(NREGS),
  localparam int unsigned SEL_W = IDX_W + 1
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                valid_i,
  input logic [3:0]          op_i,
  input logic                split_i,
  input logic [SEL_W-1:0]    src_a_i,
  input logic [SEL_W-1:0]    src_b_i,
  input logic [SEL_W-1:0]    dst_i,
  input logic [NREGS*DW-1:0] regs_i
);
  logic [DW-1:0]     r [NREGS];
  logic [IDX_W-1:0]  dphys_q;
  logic              dhalf_q;
  logic [DW-1:0]     a_full, b_full;
  logic [LANE_W-1:0] a_half, b_half, dst_other, cur_half, cur_other;

  for (genvar k = 0; k < NREGS; k++) begin : g_unpack
    assign r[k] = regs_i[k*DW +: DW];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dphys_q <= '0;
      dhalf_q <= 1'b0;
    end else begin
      dphys_q <= dst_i[SEL_W-1:1];
      dhalf_q <= dst_i[0];
    end
  end

  assign a_full    = r[src_a_i[SEL_W-1:1]];
  assign b_full    = r[src_b_i[SEL_W-1:1]];
  assign a_half    = src_a_i[0] ? a_full[DW-1:LANE_W] : a_full[LANE_W-1:0];
  assign b_half    = src_b_i[0] ? b_full[DW-1:LANE_W] : b_full[LANE_W-1:0];
  assign dst_other = dst_i[0] ? r[dst_i[SEL_W-1:1]][LANE_W-1:0] : r[dst_i[SEL_W-1:1]][DW-1:LANE_W];
  assign cur_half  = dhalf_q ? r[dphys_q][DW-1:LANE_W] : r[dphys_q][LANE_W-1:0];
  assign cur_other = dhalf_q ? r[dphys_q][LANE_W-1:0] : r[dphys_q][DW-1:LANE_W];

  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(regs_i));

  p_bad_op_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i > 4'd10) |=> $stable(regs_i));

  for (genvar k = 0; k < NREGS; k++) begin : g_other
    p_other_reg_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (dst_i[SEL_W-1:1] != IDX_W'(k)) |=> $stable(r[k]));
  end

  p_half_keep_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_i) |=> (cur_other == $past(dst_other)));

  p_add_wide_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_i && op_i == 4'd0) |=> (r[dphys_q] == $past(a_full + b_full)));

  p_add_lane_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && split_i && op_i == 4'd0) |=> (cur_half == $past(a_half + b_half)));

  p_xor_wide_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !split_i && op_i == 4'd2) |=> (r[dphys_q] == $past(a_full ^ b_full)));
endmodule

bind split_alu split_alu_checker #(.LANE_W(LANE_W), .NREGS(NREGS)) i_split_alu_checker (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .op_i   (op_i),
  .split_i(split_i),
  .src_a_i(src_a_i),
  .src_b_i(src_b_i),
  .dst_i  (dst_i),
  .regs_i (rf_flat)
);

// File: tb/test_split_alu.sv
module test_split_alu;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [3:0]  op_i = '0;
  logic        split_i = 1'b0;
  logic [2:0]  src_a_i = '0, src_b_i = '0, dst_i = '0;
  logic [63:0] imm_i = '0;
  logic [1:0]  rd_sel_i = '0;
  logic [63:0] rd_data_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [63:0] mdl [4];

  always #5ns clk_i = ~clk_i;

  split_alu i_split_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .split_i(split_i), .src_a_i(src_a_i), .src_b_i(src_b_i), .dst_i(dst_i),
    .imm_i(imm_i), .rd_sel_i(rd_sel_i), .rd_data_o(rd_data_o)
  );

  function automatic logic [63:0] rol64(logic [63:0] x, int n);
    return (n == 0) ? x : ((x << n) | (x >> (64 - n)));
  endfunction

  function automatic logic [31:0] rol32(logic [31:0] x, int n);
    return (n == 0) ? x : ((x << n) | (x >> (32 - n)));
  endfunction

  function automatic string tag_of(logic [3:0] op, logic sp);
    if (op <= 4'd1) return sp ? "R5" : "R4";
    if (op <= 4'd5) return "R7";
    if (op <= 4'd7) return sp ? "R9" : "R8";
    if (op <= 4'd9) return "R10";
    if (op == 4'd10) return "R11";
    return "R12";
  endfunction

  task automatic check_reg(input int k, input string tag);
    rd_sel_i = 2'(k);
    #1;
    checks++;
    if (rd_data_o !== mdl[k]) begin
      failures++;
      $display("FAIL %s reg%0d actual=%h expected=%h", tag, k, rd_data_o, mdl[k]);
    end
  endtask

  task automatic check_all(input string tag);
    for (int k = 0; k < 4; k++) check_reg(k, tag);
  endtask

  // called just after a falling edge; returns just after the next falling edge
  task automatic run_op(input logic [3:0] op, input logic sp, input logic [2:0] sa,
                        input logic [2:0] sb, input logic [2:0] d, input logic [63:0] imm,
                        input logic vld);
    logic [63:0] a64, b64, r64;
    logic [31:0] a32, b32, r32;
    a64 = mdl[sa[2:1]];
    b64 = mdl[sb[2:1]];
    a32 = sa[0] ? a64[63:32] : a64[31:0];
    b32 = sb[0] ? b64[63:32] : b64[31:0];
    case (op)
      4'd0: begin r64 = a64 + b64; r32 = a32 + b32; end
      4'd1: begin r64 = a64 - b64; r32 = a32 - b32; end
      4'd2: begin r64 = a64 ^ b64; r32 = a32 ^ b32; end
      4'd3: begin r64 = a64 & b64; r32 = a32 & b32; end
      4'd4: begin r64 = a64 | b64; r32 = a32 | b32; end
      4'd5: begin r64 = ~a64;      r32 = ~a32;      end
      4'd6: begin r64 = rol64(a64, int'(b64[5:0])); r32 = rol32(a32, int'(b32[4:0])); end
      4'd7: begin r64 = rol64(a64, (64 - int'(b64[5:0])) % 64);
                  r32 = rol32(a32, (32 - int'(b32[4:0])) % 32); end
      4'd8: begin r64 = rol64(a64, 8 * int'(b64[2:0])); r32 = rol32(a32, 8 * int'(b32[1:0])); end
      4'd9: begin r64 = rol64(a64, (64 - 8 * int'(b64[2:0])) % 64);
                  r32 = rol32(a32, (32 - 8 * int'(b32[1:0])) % 32); end
      4'd10: begin r64 = imm; r32 = imm[31:0]; end
      default: begin r64 = '0; r32 = '0; end
    endcase
    op_i = op; split_i = sp; src_a_i = sa; src_b_i = sb; dst_i = d; imm_i = imm;
    valid_i = vld;
    @(negedge clk_i);
    valid_i = 1'b0;
    if (vld && op <= 4'd10) begin
      if (!sp)      mdl[d[2:1]] = r64;
      else if (d[0]) mdl[d[2:1]][63:32] = r32;
      else          mdl[d[2:1]][31:0] = r32;
    end
  endtask

  initial begin
    for (int k = 0; k < 4; k++) mdl[k] = '0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    check_all("R1");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check_all("R1");

    // loads and wide carry across bit 31
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd0, 64'h0000_0000_FFFF_FFFF, 1'b1); check_all("R11");
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd2, 64'h1, 1'b1);                   check_all("R11");
    run_op(4'd0, 1'b0, 3'd0, 3'd2, 3'd4, '0, 1'b1);                       check_all("R4");
    run_op(4'd1, 1'b0, 3'd4, 3'd2, 3'd4, '0, 1'b1);                       check_all("R4");
    // lane add/sub with no cross-lane carry, other half kept
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd6, 64'hAAAA_AAAA_5555_5555, 1'b1); check_all("R11");
    run_op(4'd0, 1'b1, 3'd0, 3'd2, 3'd6, '0, 1'b1);                       check_all("R5");
    check_reg(3, "R6");
    run_op(4'd1, 1'b1, 3'd6, 3'd2, 3'd7, '0, 1'b1);                       check_all("R5");
    check_reg(3, "R6");
    run_op(4'd10, 1'b1, 3'd0, 3'd0, 3'd1, 64'hDEAD_BEEF_1234_5678, 1'b1); check_all("R11");
    // virtual register addressing: upper half of reg0 as source
    run_op(4'd2, 1'b1, 3'd1, 3'd0, 3'd5, '0, 1'b1);                       check_all("R2");
    run_op(4'd5, 1'b0, 3'd6, 3'd0, 3'd0, '0, 1'b1);                       check_all("R7");
    // rotate amounts at the wrap points
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd2, 64'hFFFF_FFFF_FFFF_FFC0, 1'b1); check_all("R11");
    run_op(4'd6, 1'b0, 3'd6, 3'd2, 3'd4, '0, 1'b1);                       check_all("R8");
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd2, 64'h3F, 1'b1);                  check_all("R11");
    run_op(4'd7, 1'b0, 3'd6, 3'd2, 3'd4, '0, 1'b1);                       check_all("R8");
    run_op(4'd6, 1'b1, 3'd7, 3'd2, 3'd5, '0, 1'b1);                       check_all("R9");
    run_op(4'd7, 1'b1, 3'd6, 3'd2, 3'd4, '0, 1'b1);                       check_all("R9");
    run_op(4'd8, 1'b0, 3'd6, 3'd2, 3'd4, '0, 1'b1);                       check_all("R10");
    run_op(4'd9, 1'b1, 3'd6, 3'd2, 3'd5, '0, 1'b1);                       check_all("R10");
    // idle and unused opcodes
    run_op(4'd10, 1'b0, 3'd0, 3'd0, 3'd0, 64'h1111_2222_3333_4444, 1'b0); check_all("R3");
    run_op(4'd13, 1'b0, 3'd0, 3'd0, 3'd0, 64'h1111_2222_3333_4444, 1'b1); check_all("R12");

    for (int i = 0; i < 600; i++) begin
      logic [3:0] op;
      logic sp;
      op = ($urandom % 8 == 0) ? 4'(11 + $urandom % 5) : 4'($urandom % 11);
      sp = 1'($urandom);
      run_op(op, sp, 3'($urandom), 3'($urandom), 3'($urandom),
             {$urandom, $urandom}, ($urandom % 6) != 0);
      check_all(tag_of(op, sp));
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule